// File: doc/BRIEF.md
# Prescaled Down-Counting Interrupt Timer

This block is a 32-bit interrupt timer that counts down on ticks of a prescaled clock. Software programs it through a small register port: an entry that holds the request vector, a mask bit and a periodic/one-shot selector; a starting count; and a divide setting that picks one of eight prescale ratios from 1 to 128. Each time the count expires, and the mask is clear, the timer emits a one-cycle request that carries the 8-bit vector. The request is edge-type, so the consumer must latch the pulse.

In one-shot mode the count runs down to zero, stays there, and raises one request. In periodic mode the count reloads and the timer repeats with a period of the starting count plus one ticks. The live count can be read at any time. Writing the starting count restarts the timer at once. Rewriting the control entry changes the mask, mode or vector but leaves the running count untouched.

Top module: `lt_timer`

## Requirements
- R1: After reset, the control entry (index 0x32) reads 0x0001_0000, with the mask set. The starting count (0x38), the live count (0x39) and the divide setting (0x3E) all read 0. No request is raised.
- R2: A write to the divide setting stores only bits 3, 1 and 0 of the data (mask 0xB). A read returns the stored value.
- R3: The prescale code is {bit3, bit1, bit0} of the divide setting, and the shift is (code + 1) mod 8. Code 7 divides by 1, code 0 by 2 and code 6 by 128. A free-running prescaler starts at reset. A tick falls on every clock edge whose count since reset release is a multiple of 2^shift.
- R4: A write to the starting count loads that value into the live count on the write edge, which restarts the timer.
- R5: In one-shot mode (control bit 17 = 0), each tick lowers the live count by one until it reaches 0, and the count then holds at 0. A single request is raised on tick N+1 after a load of N.
- R6: In periodic mode (control bit 17 = 1), the tick that finds the count at 0 reloads it with N and raises a request. Requests come every N+1 ticks, so the live count equals N − (elapsed ticks mod (N+1)).
- R7: While the mask (control bit 16) is set, expiries raise no request. A write to the control entry does not restart or change the live count.
- R8: A request appears as `irqValid` high for exactly one cycle, one cycle after the expiring tick edge. `irqVector` equals control bits 7:0.
- R9: A starting count of 0 stops the timer: the live count stays 0 and no request is raised in either mode.
- R10: The control entry stores only bits 17, 16 and 7:0. Writes to the live count are ignored. Reads of unmapped indices return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| irqValid | output | 1 | One-cycle timer request |
| irqVector | output | 8 | Vector carried with the request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 32-bit data and a 7-bit prescaler. The full prescaler width lets the bench select divide ratios of 1, 2, 16 and 128 through the divide codes alone. Because the prescaler runs freely from reset, the bench predicts every tick edge from its own cycle count since reset and checks exact request cycles even at divide-by-128. Short starting counts of 1 to 10 keep expiry, periodic reload and the mask/unmask phase within a few hundred cycles.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int SHIFT_W = 3;
  localparam int VEC_W   = 8;

  localparam logic [7:0] IDX_CTRL = 8'h32;
  localparam logic [7:0] IDX_INIT = 8'h38;
  localparam logic [7:0] IDX_CUR  = 8'h39;
  localparam logic [7:0] IDX_DIV  = 8'h3E;

  typedef struct packed {
    logic               loadInit;
    logic               periodic;
    logic               masked;
    logic [SHIFT_W-1:0] shift;
    logic [VEC_W-1:0]   vector;
  } ctrlStrobes_t;
endpackage

// File: rtl/lt_ctrl.sv
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  curCount,
  input  logic [CNT_W-1:0]  initCount,
  output logic [DATA_W-1:0] regRdata,
  output logic [CNT_W-1:0]  loadValue,
  output ctrlStrobes_t      strobes
);
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  logic [VEC_W-1:0] ctrlVec;
  logic             ctrlMask;
  logic             ctrlPeriodic;
  logic [3:0]       divReg;
  logic [2:0]       divCode;

  logic hitCtrl, hitInit, hitCur, hitDiv;
  assign hitCtrl = (regAddr == ADDR_W'(IDX_CTRL));
  assign hitInit = (regAddr == ADDR_W'(IDX_INIT));
  assign hitCur  = (regAddr == ADDR_W'(IDX_CUR));
  assign hitDiv  = (regAddr == ADDR_W'(IDX_DIV));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlVec      <= '0;
      ctrlMask     <= 1'b1;
      ctrlPeriodic <= 1'b0;
      divReg       <= '0;
    end else if (regWe) begin
      if (hitCtrl) begin
        ctrlVec      <= regWdata[VEC_W-1:0];
        ctrlMask     <= regWdata[MASK_BIT];
        ctrlPeriodic <= regWdata[PER_BIT];
      end
      if (hitDiv) divReg <= regWdata[3:0] & 4'hB;
    end
  end

  assign divCode = {divReg[3], divReg[1:0]};

  always_comb begin
    strobes.loadInit = regWe && hitInit;
    strobes.periodic = ctrlPeriodic;
    strobes.masked   = ctrlMask;
    strobes.shift    = SHIFT_W'(divCode + 3'd1);
    strobes.vector   = ctrlVec;
  end
  assign loadValue = CNT_W'(regWdata);

  always_comb begin
    regRdata = '0;
    if (hitCtrl) begin
      regRdata[VEC_W-1:0] = ctrlVec;
      regRdata[MASK_BIT]  = ctrlMask;
      regRdata[PER_BIT]   = ctrlPeriodic;
    end else if (hitInit) regRdata = DATA_W'(initCount);
    else if (hitCur)      regRdata = DATA_W'(curCount);
    else if (hitDiv)      regRdata = DATA_W'(divReg);
  end

  // R2: divide setting keeps only bits 3, 1, 0
  a_r2_divide_mask: assert property (@(posedge clk) disable iff (rst)
    (regWe && hitDiv) |=> (regRdata == DATA_W'(0) || !hitDiv || divReg == ($past(regWdata[3:0]) & 4'hB)));

  // R10: control entry write keeps mask and mode fields
  a_r10_ctrl_fields: assert property (@(posedge clk) disable iff (rst)
    (regWe && hitCtrl) |=> (ctrlMask == $past(regWdata[MASK_BIT]) && ctrlPeriodic == $past(regWdata[PER_BIT])));
endmodule

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] curCount,
  output logic [CNT_W-1:0] initCount,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   shiftOne;
  logic [PRE_W-1:0] lowMask;
  logic             tick;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + 1'b1;
  end

  assign shiftOne = (PRE_W+1)'(1) << strobes.shift;
  assign lowMask  = shiftOne[PRE_W-1:0] - 1'b1;
  assign tick     = ((preCnt & lowMask) == lowMask);

  always_ff @(posedge clk) begin
    if (rst) begin
      initCount <= '0;
      curCount  <= '0;
      armed     <= 1'b0;
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid <= 1'b0;
      if (strobes.loadInit) begin
        initCount <= loadValue;
        curCount  <= loadValue;
        armed     <= (loadValue != '0);
      end else if (armed && tick) begin
        if (curCount != '0) begin
          curCount <= curCount - 1'b1;
        end else begin
          if (!strobes.masked) begin
            irqValid  <= 1'b1;
            irqVector <= strobes.vector;
          end
          if (strobes.periodic) curCount <= initCount;
          else                  armed    <= 1'b0;
        end
      end
    end
  end

  // R4: a load shows up in the live count on the next cycle
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    strobes.loadInit |=> (curCount == $past(loadValue)));

  // R5: one-shot count holds at zero
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (curCount == '0 && !strobes.loadInit && !strobes.periodic) |=> (curCount == '0));

  // R7: masked expiries raise nothing
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    strobes.masked |=> !irqValid);

  // R8: request is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    irqValid |=> !irqValid);

  // R9: zero starting count yields no request next cycle
  a_r9_zero_stop: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadInit && loadValue == '0) |=> (curCount == '0 && !irqValid));
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] curCount;
  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] loadValue;

  lt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .curCount(curCount), .initCount(initCount), .regRdata(regRdata),
    .loadValue(loadValue), .strobes(strobes)
  );

  lt_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .loadValue(loadValue),
    .curCount(curCount), .initCount(initCount),
    .irqValid(irqValid), .irqVector(irqVector)
  );
endmodule

// File: tb/lt_timer_bench.sv
`timescale 1ns/1ps
module lt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqValid;
  logic [7:0]  irqVector;

  always #2 clk = ~clk;

  lt_timer u_lt_timer (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqValid(irqValid), .irqVector(irqVector)
  );

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  typedef struct { int cycle; logic [7:0] vec; } exp_t;
  exp_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int lastWr  = 0;
  bit done    = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected requests as the design raises them
  always @(negedge clk) begin
    if (!rst && irqValid) begin
      exp_t it;
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R8: unexpected request at cycle %0d vector %h, expected none", cyc, irqVector);
      end else begin
        it = expQ.pop_front();
        if (it.cycle != cyc || it.vec != irqVector) begin
          nFails++;
          $display("FAIL R8: request at cycle %0d vector %h, expected cycle %0d vector %h",
                   cyc, irqVector, it.cycle, it.vec);
        end
      end
    end
  end

  function automatic void expectIrq(int c, logic [7:0] v);
    expQ.push_back('{cycle: c, vec: v});
  endfunction

  function automatic int firstTick(int e, int s);
    return ((e >> s) + 1) << s;
  endfunction

  // called at a negedge; write lands on the next edge
  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    lastWr = cyc;
    regWe = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int e, eL, eU, k, ft;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdReg(8'h32, r); chk("R1 ctrl", r, 32'h0001_0000);
    rdReg(8'h38, r); chk("R1 init", r, 32'h0);
    rdReg(8'h39, r); chk("R1 cur", r, 32'h0);
    rdReg(8'h3E, r); chk("R1 div", r, 32'h0);
    chk("R1 irq", {31'b0, irqValid}, 32'h0);

    // R2 divide mask; leaves code 7 (divide by 1)
    wrReg(8'h3E, 32'hFFFF_FFFF);
    rdReg(8'h3E, r); chk("R2 div mask", r, 32'hB);

    // R10 unmapped and field masking
    rdReg(8'h10, r); chk("R10 unmapped read", r, 32'h0);
    wrReg(8'h32, 32'hFFFF_FFFF);
    rdReg(8'h32, r); chk("R10 ctrl fields", r, 32'h0003_00FF);

    // R5 one-shot, N=5, vector 0x41
    wrReg(8'h32, 32'h0000_0041);
    wrReg(8'h38, 32'd5); e = lastWr;
    expectIrq(e + 6, 8'h41);
    rdReg(8'h39, r); chk("R4 load", r, 32'd5);
    waitUntil(e + 2); rdReg(8'h39, r); chk("R5 count down", r, 32'd3);
    waitUntil(e + 5); rdReg(8'h39, r); chk("R5 reach zero", r, 32'd0);
    waitUntil(e + 20); rdReg(8'h39, r); chk("R5 hold zero", r, 32'd0);

    // R10 live count is read-only
    wrReg(8'h38, 32'd10); e = lastWr;
    expectIrq(e + 11, 8'h41);
    wrReg(8'h39, 32'h1234);
    rdReg(8'h39, r); chk("R10 cur read-only", r, 32'(10 - (lastWr - e)));
    wrReg(8'h20, 32'hFFFF);
    rdReg(8'h39, r); chk("R10 unmapped write", r, 32'(10 - (lastWr - e)));
    waitUntil(e + 25);

    // R6 periodic, N=3, vector 0x55
    wrReg(8'h32, 32'h0002_0055);
    wrReg(8'h38, 32'd3); e = lastWr;
    expectIrq(e + 4, 8'h55); expectIrq(e + 8, 8'h55); expectIrq(e + 12, 8'h55);
    waitUntil(e + 5); rdReg(8'h39, r); chk("R6 reload count", r, 32'd2);
    waitUntil(e + 13);
    wrReg(8'h38, 32'd0);                      // R9 stop
    waitUntil(e + 40);
    rdReg(8'h39, r); chk("R9 stopped", r, 32'd0);

    // R7 masked periodic, then unmask without restart
    wrReg(8'h32, 32'h0003_0066);
    wrReg(8'h38, 32'd2); eL = lastWr;
    waitUntil(eL + 20);
    wrReg(8'h32, 32'h0002_0066); eU = lastWr;
    rdReg(8'h39, r); chk("R7 no restart", r, 32'(2 - ((eU - eL) % 3)));
    k = (eU - eL) / 3 + 1;
    expectIrq(eL + 3 * k, 8'h66); expectIrq(eL + 3 * k + 3, 8'h66);
    waitUntil(eL + 3 * k + 4);
    wrReg(8'h38, 32'd0);
    waitUntil(cyc + 10);

    // R3 divide by 2 (code 0), periodic N=3
    wrReg(8'h3E, 32'h0);
    rdReg(8'h3E, r); chk("R3 div code0", r, 32'h0);
    wrReg(8'h32, 32'h0002_0077);
    wrReg(8'h38, 32'd3); e = lastWr;
    ft = firstTick(e, 1);
    expectIrq(ft + 6, 8'h77); expectIrq(ft + 14, 8'h77);
    waitUntil(ft + 15);
    wrReg(8'h38, 32'd0);
    waitUntil(cyc + 20);

    // R3 divide by 128 (code 6), one-shot N=2
    wrReg(8'h3E, 32'hA);
    wrReg(8'h32, 32'h0000_0088);
    wrReg(8'h38, 32'd2); e = lastWr;
    expectIrq(firstTick(e, 7) + 256, 8'h88);
    waitUntil(firstTick(e, 7) + 270);

    // R3 divide by 16 (code 3), one-shot N=1
    wrReg(8'h3E, 32'h3);
    wrReg(8'h38, 32'd1); e = lastWr;
    expectIrq(firstTick(e, 4) + 16, 8'h88);
    waitUntil(firstTick(e, 4) + 40);

    // R9 periodic with zero count never fires
    wrReg(8'h32, 32'h0002_0099);
    wrReg(8'h38, 32'd0);
    waitUntil(cyc + 300);
    rdReg(8'h39, r); chk("R9 zero periodic", r, 32'd0);

    while (expQ.size() > 0) begin
      exp_t it = expQ.pop_front();
      nChecks++; nFails++;
      $display("FAIL R8: missing request got none expected cycle %0d vector %h", it.cycle, it.vec);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule